// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control state machine of a multi-cycle 32-bit processor. The processor shares one memory between instructions and data. A single ALU does the arithmetic, the program-counter increment and the branch-target addition. Each instruction takes several clock cycles. In every cycle the controller drives the strobes that steer the datapath: program-counter write and source, memory read and write, address selection, instruction- and data-register capture, register-file write and its routing, operand latch enables, ALU operation, ALU operand selects and result-register capture.

The controller reads the 6-bit opcode from the instruction register and the ALU zero flag. It has ten states. Fetch and decode are shared by all instruction classes, and the decode step computes the branch target ahead of time. The controller then branches into per-class sequences for register arithmetic, load, store, branch-if-equal and jump. Every strobe is a function of the current state only. The one exception is the combined program-counter write, which also uses the zero flag. A parameter chooses binary or one-hot state encoding.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in the fetch state. In the cycle after a reset edge, the outputs show the fetch strobe set, whatever state was active before.
- R2: Fetch asserts mem_rd=1, addr_sel=0, ir_wr=1, alu_op=0 (add), alu_a_sel=0 (PC), alu_b_sel=1 (constant four), pc_wr_uncond=1 and pc_src=1 (ALU output). The next state is always decode.
- R3: Decode asserts a_wr=1, b_wr=1, res_wr=1, alu_op=0, alu_a_sel=0 and alu_b_sel=3 (scaled offset). It then dispatches on the opcode: 6'b000000 goes to register execute, 6'b100011 (load) and 6'b101011 (store) go to address compute, 6'b000100 goes to branch, and 6'b000010 goes to jump.
- R4: Register execute asserts alu_op=2 (function field), alu_a_sel=1, alu_b_sel=0 and res_wr=1. It is followed by a write-back cycle with rf_wr=1, dst_sel=1 (rd) and wb_sel=0 (result). The controller then returns to fetch, so the class takes four cycles.
- R5: Address compute asserts alu_op=0, alu_a_sel=1, alu_b_sel=2 (immediate) and res_wr=1. It continues to the store cycle when the opcode is 6'b101011, and otherwise to the load cycle.
- R6: The store cycle asserts mem_wr=1 and addr_sel=1, then returns to fetch, so a store takes four cycles.
- R7: The load cycle asserts mem_rd=1, addr_sel=1 and dr_wr=1. It is followed by a write-back cycle with rf_wr=1, dst_sel=0 (rt) and wb_sel=1 (data register), then fetch, so a load takes five cycles.
- R8: The branch cycle asserts alu_op=1 (subtract), alu_a_sel=1, alu_b_sel=0, pc_wr_cond=1 and pc_src=0 (result register), with res_wr=0. pc_wr then equals zero, and the next state is fetch.
- R9: The jump cycle asserts pc_wr_uncond=1 and pc_src=2 (jump target), then returns to fetch.
- R10: In every cycle, pc_wr equals pc_wr_uncond OR (zero AND pc_wr_cond). In any state other than branch, zero has no effect on any output.
- R11: Any opcode outside the five listed sends decode straight back to fetch.
- R12: Every strobe and select that a state does not name is driven to 0. mem_rd and mem_wr are never both high.
- R13: The opcode is consulted only in decode and address compute. Changing it in any other state does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W (6) | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Combined program-counter write enable |
| pc_wr_uncond | output | 1 | Unconditional PC write request |
| pc_wr_cond | output | 1 | PC write request qualified by zero |
| pc_src | output | 2 | PC source: 0 result register, 1 ALU, 2 jump target |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 result register |
| ir_wr | output | 1 | Instruction register capture |
| dr_wr | output | 1 | Data register capture |
| rf_wr | output | 1 | Register-file write |
| dst_sel | output | 1 | Destination index: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 result, 1 data register |
| a_wr | output | 1 | Operand A latch enable |
| b_wr | output | 1 | Operand B latch enable |
| alu_op | output | 2 | ALU operation: 0 add, 1 subtract, 2 function field |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 operand A |
| alu_b_sel | output | 2 | ALU B input: 0 operand B, 1 four, 2 immediate, 3 scaled offset |
| res_wr | output | 1 | Result register capture |

## Verification
Each instruction class is stepped through its full sequence, and the whole strobe vector is compared with a behavioural model in every cycle. The per-class path lengths (four, five and three cycles) tell apart a misrouted dispatch from a wrong strobe. The branch is run with zero low and with zero high, and zero is also toggled during fetch and jump, which separates conditional from unconditional PC writes. An unknown opcode, opcode changes in states that must ignore it, and a reset taken in the middle of a load check the fetch recovery paths.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam int N_STATES = 10;
   localparam int STATE_W  = 4;

   typedef enum logic [STATE_W-1:0] {
      S_FETCH  = 4'd0,
      S_DECODE = 4'd1,
      S_EXEC   = 4'd2,
      S_RWB    = 4'd3,
      S_MADDR  = 4'd4,
      S_STORE  = 4'd5,
      S_LOAD   = 4'd6,
      S_LWB    = 4'd7,
      S_BRANCH = 4'd8,
      S_JUMP   = 4'd9
   } ctl_state_e;

   localparam logic [1:0] ALU_ADD   = 2'd0;
   localparam logic [1:0] ALU_SUB   = 2'd1;
   localparam logic [1:0] ALU_FUNCT = 2'd2;

   localparam logic [1:0] PCS_RES = 2'd0;
   localparam logic [1:0] PCS_ALU = 2'd1;
   localparam logic [1:0] PCS_JMP = 2'd2;

   localparam logic [1:0] BSEL_REG  = 2'd0;
   localparam logic [1:0] BSEL_FOUR = 2'd1;
   localparam logic [1:0] BSEL_IMM  = 2'd2;
   localparam logic [1:0] BSEL_OFFS = 2'd3;

   typedef struct packed {
      logic       pc_unc;
      logic       pc_cond;
      logic [1:0] pc_src;
      logic       mem_rd;
      logic       mem_wr;
      logic       addr_sel;
      logic       ir_wr;
      logic       dr_wr;
      logic       rf_wr;
      logic       dst_sel;
      logic       wb_sel;
      logic       a_wr;
      logic       b_wr;
      logic [1:0] alu_op;
      logic       a_sel;
      logic [1:0] b_sel;
      logic       res_wr;
   } strobe_t;

endpackage

// File: rtl/mcc_seq.sv
module mcc_seq
   import mcc_pkg::*;
#(
   parameter int               OPC_W     = 6,
   parameter logic [OPC_W-1:0] OP_RTYPE  = 6'b000000,
   parameter logic [OPC_W-1:0] OP_LOAD   = 6'b100011,
   parameter logic [OPC_W-1:0] OP_STORE  = 6'b101011,
   parameter logic [OPC_W-1:0] OP_BEQ    = 6'b000100,
   parameter logic [OPC_W-1:0] OP_JUMP   = 6'b000010,
   parameter bit               ONE_HOT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   output ctl_state_e       state
);

   localparam logic [N_STATES-1:0] HOT_FETCH = {{(N_STATES-1){1'b0}}, 1'b1};

   ctl_state_e nxt;

   always_comb begin
      case (state)
         S_FETCH:  nxt = S_DECODE;
         S_DECODE: begin
            if (opcode == OP_RTYPE)                            nxt = S_EXEC;
            else if (opcode == OP_LOAD || opcode == OP_STORE)  nxt = S_MADDR;
            else if (opcode == OP_BEQ)                         nxt = S_BRANCH;
            else if (opcode == OP_JUMP)                        nxt = S_JUMP;
            else                                               nxt = S_FETCH;
         end
         S_EXEC:   nxt = S_RWB;
         S_MADDR:  nxt = (opcode == OP_STORE) ? S_STORE : S_LOAD;
         S_LOAD:   nxt = S_LWB;
         default:  nxt = S_FETCH;
      endcase
   end

   generate
      if (ONE_HOT) begin : g_hot
         logic [N_STATES-1:0] hot_q;
         logic [STATE_W-1:0]  idx;

         always_ff @(posedge clk) begin
            if (rst) hot_q <= HOT_FETCH;
            else     hot_q <= HOT_FETCH << nxt;
         end

         always_comb begin
            idx = '0;
            for (int i = 0; i < N_STATES; i++)
               if (hot_q[i]) idx = idx | STATE_W'(i);
         end
         assign state = ctl_state_e'(idx);

         p_state_hot_r1: assert property (@(posedge clk) disable iff (rst)
            $onehot(hot_q));
      end else begin : g_bin
         ctl_state_e state_q;
         always_ff @(posedge clk) begin
            if (rst) state_q <= S_FETCH;
            else     state_q <= nxt;
         end
         assign state = state_q;
      end
   endgenerate

   p_reset_fetch_r1: assert property (@(posedge clk)
      rst |=> state == S_FETCH);

   p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
      state == S_FETCH |=> state == S_DECODE);

   p_dispatch_rtype_r3: assert property (@(posedge clk) disable iff (rst)
      (state == S_DECODE && opcode == OP_RTYPE) |=> state == S_EXEC);

   p_split_store_r5: assert property (@(posedge clk) disable iff (rst)
      (state == S_MADDR && opcode == OP_STORE) |=> state == S_STORE);

   p_unknown_op_r11: assert property (@(posedge clk) disable iff (rst)
      (state == S_DECODE && opcode != OP_RTYPE && opcode != OP_LOAD &&
       opcode != OP_STORE && opcode != OP_BEQ && opcode != OP_JUMP)
      |=> state == S_FETCH);

   p_exec_then_wb_r4: assert property (@(posedge clk) disable iff (rst)
      state == S_EXEC |=> state == S_RWB);

endmodule

// File: rtl/mcc_strobes.sv
module mcc_strobes
   import mcc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  ctl_state_e state,
   output strobe_t    stb
);

   always_comb begin
      stb = '0;
      case (state)
         S_FETCH: begin
            stb.mem_rd   = 1'b1;
            stb.addr_sel = 1'b0;
            stb.ir_wr    = 1'b1;
            stb.alu_op   = ALU_ADD;
            stb.a_sel    = 1'b0;
            stb.b_sel    = BSEL_FOUR;
            stb.pc_unc   = 1'b1;
            stb.pc_src   = PCS_ALU;
         end
         S_DECODE: begin
            stb.a_wr   = 1'b1;
            stb.b_wr   = 1'b1;
            stb.alu_op = ALU_ADD;
            stb.a_sel  = 1'b0;
            stb.b_sel  = BSEL_OFFS;
            stb.res_wr = 1'b1;
         end
         S_EXEC: begin
            stb.alu_op = ALU_FUNCT;
            stb.a_sel  = 1'b1;
            stb.b_sel  = BSEL_REG;
            stb.res_wr = 1'b1;
         end
         S_RWB: begin
            stb.rf_wr   = 1'b1;
            stb.dst_sel = 1'b1;
            stb.wb_sel  = 1'b0;
         end
         S_MADDR: begin
            stb.alu_op = ALU_ADD;
            stb.a_sel  = 1'b1;
            stb.b_sel  = BSEL_IMM;
            stb.res_wr = 1'b1;
         end
         S_STORE: begin
            stb.mem_wr   = 1'b1;
            stb.addr_sel = 1'b1;
         end
         S_LOAD: begin
            stb.mem_rd   = 1'b1;
            stb.addr_sel = 1'b1;
            stb.dr_wr    = 1'b1;
         end
         S_LWB: begin
            stb.rf_wr   = 1'b1;
            stb.dst_sel = 1'b0;
            stb.wb_sel  = 1'b1;
         end
         S_BRANCH: begin
            stb.alu_op  = ALU_SUB;
            stb.a_sel   = 1'b1;
            stb.b_sel   = BSEL_REG;
            stb.pc_cond = 1'b1;
            stb.pc_src  = PCS_RES;
         end
         S_JUMP: begin
            stb.pc_unc = 1'b1;
            stb.pc_src = PCS_JMP;
         end
         default: stb = '0;
      endcase
   end

   p_mem_excl_r12: assert property (@(posedge clk) disable iff (rst)
      !(stb.mem_rd && stb.mem_wr));

   p_ir_then_latch_r2: assert property (@(posedge clk) disable iff (rst)
      stb.ir_wr |=> (stb.a_wr && stb.b_wr));

   p_cond_alone_r8: assert property (@(posedge clk) disable iff (rst)
      stb.pc_cond |-> (!stb.pc_unc && !stb.res_wr));

endmodule

// File: rtl/mcc_pcw.sv
module mcc_pcw (
   input  logic clk,
   input  logic rst,
   input  logic pc_unc,
   input  logic pc_cond,
   input  logic zero,
   output logic pc_wr
);

   assign pc_wr = pc_unc | (zero & pc_cond);

   p_unc_wins_r10: assert property (@(posedge clk) disable iff (rst)
      pc_unc |-> pc_wr);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      (!pc_unc && !pc_cond) |-> !pc_wr);

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
   import mcc_pkg::*;
#(
   parameter int               OPC_W    = 6,
   parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
   parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
   parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
   parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
   parameter logic [OPC_W-1:0] OP_JUMP  = 6'b000010,
   parameter bit               ONE_HOT  = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic             zero,
   output logic             pc_wr,
   output logic             pc_wr_uncond,
   output logic             pc_wr_cond,
   output logic [1:0]       pc_src,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             addr_sel,
   output logic             ir_wr,
   output logic             dr_wr,
   output logic             rf_wr,
   output logic             dst_sel,
   output logic             wb_sel,
   output logic             a_wr,
   output logic             b_wr,
   output logic [1:0]       alu_op,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic             res_wr
);

   generate
      if (OPC_W < 3) begin : g_bad_width
         $error("mcc_ctrl: OPC_W too narrow to hold five distinct opcodes");
      end
      if (OP_RTYPE == OP_LOAD || OP_RTYPE == OP_STORE || OP_RTYPE == OP_BEQ ||
          OP_RTYPE == OP_JUMP || OP_LOAD == OP_STORE || OP_LOAD == OP_BEQ ||
          OP_LOAD == OP_JUMP || OP_STORE == OP_BEQ || OP_STORE == OP_JUMP ||
          OP_BEQ == OP_JUMP) begin : g_bad_codes
         $error("mcc_ctrl: opcode parameters must be distinct");
      end
   endgenerate

   ctl_state_e state;
   strobe_t    stb;

   mcc_seq #(
      .OPC_W    (OPC_W),
      .OP_RTYPE (OP_RTYPE),
      .OP_LOAD  (OP_LOAD),
      .OP_STORE (OP_STORE),
      .OP_BEQ   (OP_BEQ),
      .OP_JUMP  (OP_JUMP),
      .ONE_HOT  (ONE_HOT)
   ) u_seq (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .state  (state)
   );

   mcc_strobes u_strobes (
      .clk   (clk),
      .rst   (rst),
      .state (state),
      .stb   (stb)
   );

   mcc_pcw u_pcw (
      .clk     (clk),
      .rst     (rst),
      .pc_unc  (stb.pc_unc),
      .pc_cond (stb.pc_cond),
      .zero    (zero),
      .pc_wr   (pc_wr)
   );

   assign pc_wr_uncond = stb.pc_unc;
   assign pc_wr_cond   = stb.pc_cond;
   assign pc_src       = stb.pc_src;
   assign mem_rd       = stb.mem_rd;
   assign mem_wr       = stb.mem_wr;
   assign addr_sel     = stb.addr_sel;
   assign ir_wr        = stb.ir_wr;
   assign dr_wr        = stb.dr_wr;
   assign rf_wr        = stb.rf_wr;
   assign dst_sel      = stb.dst_sel;
   assign wb_sel       = stb.wb_sel;
   assign a_wr         = stb.a_wr;
   assign b_wr         = stb.b_wr;
   assign alu_op       = stb.alu_op;
   assign alu_a_sel    = stb.a_sel;
   assign alu_b_sel    = stb.b_sel;
   assign res_wr       = stb.res_wr;

   p_rd_wb_after_res_r4: assert property (@(posedge clk) disable iff (rst)
      (rf_wr && !wb_sel) |-> $past(res_wr));

   p_rt_wb_after_dr_r7: assert property (@(posedge clk) disable iff (rst)
      (rf_wr && wb_sel) |-> $past(dr_wr));

   p_store_after_addr_r6: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> ($past(res_wr) && $past(alu_b_sel) == BSEL_IMM));

   p_jump_from_decode_r9: assert property (@(posedge clk) disable iff (rst)
      (pc_wr_uncond && pc_src == PCS_JMP) |-> $past(a_wr));

endmodule

// File: tb/mcc_ctrl_tb.sv
module mcc_ctrl_tb;

   localparam logic [5:0] C_RT = 6'b000000;
   localparam logic [5:0] C_LW = 6'b100011;
   localparam logic [5:0] C_SW = 6'b101011;
   localparam logic [5:0] C_BQ = 6'b000100;
   localparam logic [5:0] C_J  = 6'b000010;
   localparam logic [5:0] C_XX = 6'b111111;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'd0;
   logic       zero = 1'b0;
   logic       pc_wr, pc_wr_uncond, pc_wr_cond, mem_rd, mem_wr, addr_sel, ir_wr;
   logic       dr_wr, rf_wr, dst_sel, wb_sel, a_wr, b_wr, alu_a_sel, res_wr;
   logic [1:0] pc_src, alu_op, alu_b_sel;

   int total = 0;
   int bad = 0;
   int mstate = 0;
   bit after_rst = 1'b0;

   always #2 clk = ~clk;

   mcc_ctrl u_dut (
      .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
      .pc_wr(pc_wr), .pc_wr_uncond(pc_wr_uncond), .pc_wr_cond(pc_wr_cond),
      .pc_src(pc_src), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
      .ir_wr(ir_wr), .dr_wr(dr_wr), .rf_wr(rf_wr), .dst_sel(dst_sel),
      .wb_sel(wb_sel), .a_wr(a_wr), .b_wr(b_wr), .alu_op(alu_op),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .res_wr(res_wr)
   );

   function automatic logic [20:0] expect_vec(int st, bit z);
      bit unc = 0, cnd = 0, mr = 0, mw = 0, ad = 0, ir = 0, dr = 0, rf = 0;
      bit ds = 0, wb = 0, aw = 0, bw = 0, as = 0, rw = 0;
      logic [1:0] ps = 0, op = 0, bs = 0;
      case (st)
         0: begin mr = 1; ir = 1; bs = 1; unc = 1; ps = 1; end
         1: begin aw = 1; bw = 1; bs = 3; rw = 1; end
         2: begin op = 2; as = 1; rw = 1; end
         3: begin rf = 1; ds = 1; end
         4: begin as = 1; bs = 2; rw = 1; end
         5: begin mw = 1; ad = 1; end
         6: begin mr = 1; ad = 1; dr = 1; end
         7: begin rf = 1; wb = 1; end
         8: begin op = 1; as = 1; cnd = 1; end
         9: begin unc = 1; ps = 2; end
         default: ;
      endcase
      return {unc | (z & cnd), unc, cnd, ps, mr, mw, ad, ir, dr, rf, ds, wb,
              aw, bw, op, as, bs, rw};
   endfunction

   function automatic int next_of(int st, logic [5:0] op);
      case (st)
         0: return 1;
         1: begin
            if (op == C_RT) return 2;
            if (op == C_LW || op == C_SW) return 4;
            if (op == C_BQ) return 8;
            if (op == C_J) return 9;
            return 0;
         end
         2: return 3;
         4: return (op == C_SW) ? 5 : 6;
         6: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int st);
      case (st)
         0: return "R2";
         1: return "R3";
         2, 3: return "R4";
         4: return "R5";
         5: return "R6";
         6, 7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic step(logic [5:0] op, bit z, bit r, string extra);
      logic [20:0] got, exp;
      string t;
      int nx;
      @(negedge clk);
      opcode = op;
      zero = z;
      rst = r;
      #1;
      got = {pc_wr, pc_wr_uncond, pc_wr_cond, pc_src, mem_rd, mem_wr, addr_sel,
             ir_wr, dr_wr, rf_wr, dst_sel, wb_sel, a_wr, b_wr, alu_op,
             alu_a_sel, alu_b_sel, res_wr};
      exp = expect_vec(mstate, z);
      t = after_rst ? "R1" : tag_of(mstate);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s R12 %s: state %0d got %b expected %b", t, extra, mstate, got, exp);
      end
      total++;
      if (pc_wr !== exp[20]) begin
         bad++;
         $display("FAIL R10 %s: pc_wr got %b expected %b", extra, pc_wr, exp[20]);
      end
      nx = r ? 0 : next_of(mstate, op);
      @(posedge clk);
      mstate = nx;
      after_rst = r;
   endtask

   // op is used in decode and address compute, alt_op elsewhere
   task automatic run(logic [5:0] op, bit z, logic [5:0] alt_op, string extra);
      step(alt_op, ~z, 1'b0, extra);
      while (mstate != 0) begin
         if (mstate == 1 || mstate == 4) step(op, z, 1'b0, extra);
         else step(alt_op, z, 1'b0, extra);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      mstate = 0;
      after_rst = 1'b1;
      step(C_RT, 1'b0, 1'b0, "reset");
      run(C_RT, 1'b0, C_RT, "rtype");
      run(C_LW, 1'b0, C_LW, "load");
      run(C_SW, 1'b1, C_SW, "store");
      run(C_BQ, 1'b0, C_BQ, "beq not taken");
      run(C_BQ, 1'b1, C_BQ, "beq taken");
      run(C_J, 1'b1, C_J, "jump zero high");
      run(C_J, 1'b0, C_J, "jump zero low");
      run(C_XX, 1'b0, C_XX, "R11 unknown opcode");
      run(6'b001000, 1'b1, C_XX, "R11 other opcode");
      run(C_RT, 1'b1, C_SW, "R13 rtype opcode changed");
      run(C_LW, 1'b1, C_J, "R13 load opcode changed");
      run(C_SW, 1'b0, C_BQ, "R13 store opcode changed");
      // reset taken in the middle of a load
      step(C_LW, 1'b0, 1'b0, "R1 mid reset");
      step(C_LW, 1'b0, 1'b0, "R1 mid reset");
      step(C_LW, 1'b0, 1'b0, "R1 mid reset");
      step(C_LW, 1'b0, 1'b1, "R1 mid reset");
      step(C_LW, 1'b1, 1'b0, "R1 after reset");
      run(C_BQ, 1'b1, C_BQ, "beq after reset");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule